// File: doc/BRIEF.md
# External Interrupt Sensitivity Unit

This block turns fifteen external pins into four external interrupt requests. Each request has its own trigger condition. The pins come from three ports and form four groups. Source 0 takes port A bits 3..0. Source 1 takes port F bits 2..0. Source 2 takes the low half of port B, and source 3 takes the high half of port B.

Every pin passes through a two-flop synchroniser. Each group then feeds one detector. The detector raises its request on the selected edge and holds it until the interrupt controller acknowledges that source. In the level modes, the request follows the active level of the group instead.

A single configuration word sets the trigger conditions. It is written through a simple write port. A write is accepted only while the core's two-bit interrupt level input reads 3, which means interrupts are masked. If an accepted write changes a source's trigger condition, that source's request is dropped.

Each detector is a small state machine with three states:

- `ST_IDLE`: no request.
- `ST_EDGE_PEND`: an edge was seen and the request waits for an acknowledge.
- `ST_LEVEL_ON`: a level-mode request whose active level is still present.

The transitions are:

- *arm*: `ST_IDLE` to `ST_EDGE_PEND` on a selected edge in an edge mode.
- *hold*: stay in `ST_EDGE_PEND` while no acknowledge arrives, or while a new edge arrives.
- *release*: `ST_EDGE_PEND` to `ST_IDLE` on an acknowledge with no coincident edge.
- *assert*: `ST_IDLE` to `ST_LEVEL_ON` when a level mode sees its active level.
- *drop*: `ST_LEVEL_ON` to `ST_IDLE` when the level goes inactive.
- *flush*: any state to `ST_IDLE` when the source's configuration changes.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset, `cfg_q` is zero and no request is asserted while all pins are held high.
- R2: Pin groups map to sources as follows: `port_a[3:0]` to source 0, `port_f[2:0]` to source 1, `port_b[3:0]` to source 2 and `port_b[7:4]` to source 3. Activity in one group changes only that source's request.
- R3: With code 01 in a source's mode field, a rising edge on any pin of its group makes the request pending. The request stays pending until acknowledged. Falling edges have no effect in this mode.
- R4: With code 10, a falling edge on any pin of the group makes the request pending. Rising edges have no effect in this mode.
- R5: With code 11, a rising or a falling edge on any pin of the group makes the request pending.
- R6: With code 00 and the polarity bit clear, the request is high while any pin of the group is low (the AND of the group is 0). The request is low once all pins are high. Acknowledge has no effect in this mode.
- R7: With code 00 and the polarity bit set, the request is high while any pin of the group is high (the OR of the group is 1). This applies to sources 0 and 2 only, which are the only sources with a polarity bit.
- R8: The configuration word has the following layout:
  - bits [1:0]: mode field of source 0
  - bits [3:2]: mode field of source 1
  - bits [5:4]: mode field of source 2
  - bits [7:6]: mode field of source 3
  - bit 8: polarity of source 0
  - bit 9: polarity of source 2

  A write with `cfg_we` high loads the word on the next edge only if `irq_lvl` is 2'b11. At any other level, `cfg_q` and every request are left unchanged.
- R9: An accepted write that changes a source's mode field or its polarity bit clears that source's request at the same edge. A write that leaves those bits unchanged keeps the request.
- R10: A pin change made before rising edge k shows on `irq_req` after edge k+2.
- R11: An acknowledge pulse for a pending edge-mode source clears the request at the next edge. If a new selected edge reaches the detector in the same cycle as the acknowledge, the request stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_a | input | 4 | Pin group of source 0 |
| port_f | input | 3 | Pin group of source 1 |
| port_b | input | 8 | Pin groups of sources 2 (low half) and 3 (high half) |
| irq_lvl | input | 2 | Core interrupt level; writes are accepted at 2'b11 only |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 10 | Configuration word to write |
| cfg_q | output | 10 | Current configuration word |
| irq_ack | input | 4 | Per-source acknowledge pulse |
| irq_req | output | 4 | Per-source interrupt request |

## Verification
The hardest case to reach is an acknowledge that lands in the same cycle as a new selected edge reaching the detector. The edge only arrives after the synchroniser delay, so the acknowledge must be placed exactly two cycles after the pin toggle. The stimulus counts those cycles explicitly, in both-edge mode on source 2.

A second hard case is a request that is flushed by a configuration change. This needs a pending request, then a write that really alters that source's field at level 3, and then a write at a lower level. The directed sequence builds exactly that order. A long random phase then mixes pin toggles, acknowledges and writes at random levels, and a behavioural model is compared with the outputs every cycle.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
    localparam int NSRC  = 4;
    localparam int CFG_W = 2 * NSRC + 2;

    typedef enum logic [1:0] {
        SENS_LEVEL = 2'b00,
        SENS_RISE  = 2'b01,
        SENS_FALL  = 2'b10,
        SENS_BOTH  = 2'b11
    } sens_e;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'b00,
        ST_EDGE_PEND = 2'b01,
        ST_LEVEL_ON  = 2'b10
    } det_state_e;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
    parameter int W      = 15,
    parameter int STAGES = 2,
    parameter bit RST_HI = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins_i,
    output logic [W-1:0] pins_o
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= {W{RST_HI}};
        end else begin
            stage_q[0] <= pins_i;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign pins_o = stage_q[STAGES-1];
endmodule

// File: rtl/ext_irq_cfg.sv
module ext_irq_cfg
    import ext_irq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we_i,
    input  logic [CFG_W-1:0]      wdata_i,
    input  logic [1:0]            lvl_i,
    output logic [CFG_W-1:0]      cfg_o,
    output logic [NSRC-1:0][1:0]  sens_o,
    output logic [NSRC-1:0]       pol_o,
    output logic [NSRC-1:0]       flush_o
);
    localparam int POL0_BIT = CFG_W - 2;
    localparam int POL2_BIT = CFG_W - 1;

    logic [CFG_W-1:0] cfg_q;
    logic             wr_ok;

    assign wr_ok = we_i && (lvl_i == 2'b11);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cfg_q <= '0;
        else if (wr_ok) cfg_q <= wdata_i;
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic pol_chg;
        if (i == 0) begin : g_p0
            assign pol_o[i] = cfg_q[POL0_BIT];
            assign pol_chg  = wdata_i[POL0_BIT] != cfg_q[POL0_BIT];
        end else if (i == 2) begin : g_p2
            assign pol_o[i] = cfg_q[POL2_BIT];
            assign pol_chg  = wdata_i[POL2_BIT] != cfg_q[POL2_BIT];
        end else begin : g_np
            assign pol_o[i] = 1'b0;
            assign pol_chg  = 1'b0;
        end
        assign sens_o[i]  = cfg_q[2*i +: 2];
        assign flush_o[i] = wr_ok && ((wdata_i[2*i +: 2] != cfg_q[2*i +: 2]) || pol_chg);
    end

    assign cfg_o = cfg_q;

    // R8
    locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && lvl_i != 2'b11) |=> $stable(cfg_q));
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
    import ext_irq_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins_s,
    input  logic [1:0]   sens_i,
    input  logic         pol_i,
    input  logic         ack_i,
    input  logic         flush_i,
    output logic         req_o
);
    det_state_e   st_q, st_d;
    logic [W-1:0] prev_q;
    logic         rise, fall, hit, active, lvl_mode;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= pins_s;
    end

    assign rise     = |(pins_s & ~prev_q);
    assign fall     = |(~pins_s & prev_q);
    assign lvl_mode = (sens_e'(sens_i) == SENS_LEVEL);
    assign active   = pol_i ? (|pins_s) : ~(&pins_s);

    always_comb begin
        unique case (sens_e'(sens_i))
            SENS_RISE:  hit = rise;
            SENS_FALL:  hit = fall;
            SENS_BOTH:  hit = rise | fall;
            default:    hit = 1'b0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // transitions
    always_comb begin
        st_d = st_q;
        if (flush_i) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (lvl_mode) begin
                        if (active) st_d = ST_LEVEL_ON;
                    end else if (hit) begin
                        st_d = ST_EDGE_PEND;
                    end
                end
                ST_EDGE_PEND: if (!hit && ack_i)        st_d = ST_IDLE;
                ST_LEVEL_ON:  if (!lvl_mode || !active) st_d = ST_IDLE;
                default:                                st_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (st_q)
            ST_EDGE_PEND, ST_LEVEL_ON: req_o = 1'b1;
            default:                   req_o = 1'b0;
        endcase
    end

    // R9
    flush_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !req_o);
    // R3
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl_mode && req_o && !ack_i && !flush_i) |=> req_o);
    // R11
    ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl_mode && req_o && ack_i && !hit && !flush_i) |=> !req_o);
    // R6
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_mode && active && !flush_i) |=> req_o);
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
    import ext_irq_pkg::*;
#(
    parameter int A_W         = 4,
    parameter int F_W         = 3,
    parameter int B_W         = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [A_W-1:0]   port_a,
    input  logic [F_W-1:0]   port_f,
    input  logic [B_W-1:0]   port_b,
    input  logic [1:0]       irq_lvl,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_q,
    input  logic [NSRC-1:0]  irq_ack,
    output logic [NSRC-1:0]  irq_req
);
    localparam int PIN_W = A_W + F_W + B_W;
    localparam int BH    = B_W / 2;

    logic [PIN_W-1:0]     pins_s;
    logic [NSRC-1:0][1:0] sens;
    logic [NSRC-1:0]      pol;
    logic [NSRC-1:0]      flush;

    ext_irq_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_HI(1'b1)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i ({port_b, port_f, port_a}),
        .pins_o (pins_s)
    );

    ext_irq_cfg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we),
        .wdata_i (cfg_wdata),
        .lvl_i   (irq_lvl),
        .cfg_o   (cfg_q),
        .sens_o  (sens),
        .pol_o   (pol),
        .flush_o (flush)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_det
        localparam int LO = (i == 0) ? 0 : (i == 1) ? A_W : (i == 2) ? A_W + F_W : A_W + F_W + BH;
        localparam int GW = (i == 0) ? A_W : (i == 1) ? F_W : (i == 2) ? BH : B_W - BH;
        ext_irq_detect #(.W(GW)) u_det (
            .clk     (clk),
            .rst_n   (rst_n),
            .pins_s  (pins_s[LO +: GW]),
            .sens_i  (sens[i]),
            .pol_i   (pol[i]),
            .ack_i   (irq_ack[i]),
            .flush_i (flush[i]),
            .req_o   (irq_req[i])
        );
    end
endmodule

// File: tb/ext_irq_sense_test.sv
module ext_irq_sense_test;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] port_a = 4'hF;
    logic [2:0] port_f = 3'h7;
    logic [7:0] port_b = 8'hFF;
    logic [1:0] irq_lvl = 2'b00;
    logic       cfg_we = 1'b0;
    logic [9:0] cfg_wdata = '0;
    logic [9:0] cfg_q;
    logic [3:0] irq_ack = '0;
    logic [3:0] irq_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    ext_irq_sense uut (
        .clk(clk), .rst_n(rst_n), .port_a(port_a), .port_f(port_f), .port_b(port_b),
        .irq_lvl(irq_lvl), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
        .irq_ack(irq_ack), .irq_req(irq_req)
    );

    // behavioural reference
    logic [14:0] m_s1, m_s2, m_prev;
    logic [9:0]  m_cfg;
    logic [3:0]  m_req;

    function automatic logic [14:0] grp_mask(int s);
        case (s)
            0:       return 15'h000F;
            1:       return 15'h0070;
            2:       return 15'h0780;
            default: return 15'h7800;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = '1; m_s2 = '1; m_prev = '1; m_cfg = '0; m_req = '0;
        end else begin
            bit wr;
            wr = cfg_we && irq_lvl == 2'b11;
            for (int s = 0; s < 4; s++) begin
                logic [14:0] mk;
                logic [1:0]  sn;
                bit pl, ri, fa, act, hit, clr;
                mk  = grp_mask(s);
                sn  = m_cfg[2*s +: 2];
                pl  = (s == 0) ? m_cfg[8] : (s == 2) ? m_cfg[9] : 1'b0;
                ri  = |(m_s2 & ~m_prev & mk);
                fa  = |(~m_s2 & m_prev & mk);
                act = pl ? |(m_s2 & mk) : |(~m_s2 & mk);
                hit = (sn == 2'd1) ? ri : (sn == 2'd2) ? fa : (sn == 2'd3) ? (ri | fa) : 1'b0;
                clr = wr && ((cfg_wdata[2*s +: 2] != sn) ||
                             (s == 0 && cfg_wdata[8] != m_cfg[8]) ||
                             (s == 2 && cfg_wdata[9] != m_cfg[9]));
                if (clr)             m_req[s] = 1'b0;
                else if (sn == 2'd0) m_req[s] = act;
                else                 m_req[s] = (m_req[s] & ~irq_ack[s]) | hit;
            end
            if (wr) m_cfg = cfg_wdata;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = {port_b, port_f, port_a};
        end
    end

    function automatic string mode_tag(int s);
        logic [1:0] sn;
        sn = m_cfg[2*s +: 2];
        if (sn == 2'd1) return "R3";
        if (sn == 2'd2) return "R4";
        if (sn == 2'd3) return "R5";
        if ((s == 0 && m_cfg[8]) || (s == 2 && m_cfg[9])) return "R7";
        return "R6";
    endfunction

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int s = 0; s < 4; s++) begin
                n_chk++;
                if (irq_req[s] !== m_req[s]) begin
                    n_bad++;
                    $display("FAIL %s model src%0d req actual=%0b expected=%0b t=%0t",
                             mode_tag(s), s, irq_req[s], m_req[s], $time);
                end
            end
            n_chk++;
            if (cfg_q !== m_cfg) begin
                n_bad++;
                $display("FAIL R8 model cfg actual=%h expected=%h", cfg_q, m_cfg);
            end
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_cfg(logic [1:0] lvl, logic [9:0] d);
        irq_lvl = lvl; cfg_we = 1'b1; cfg_wdata = d;
        step(1);
        cfg_we = 1'b0; irq_lvl = 2'b00;
    endtask

    task automatic pulse_ack(logic [3:0] a);
        irq_ack = a;
        step(1);
        irq_ack = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        step(4);
        rst_n = 1'b1;
        step(3);
        check("R1 req", irq_req, 4'h0);
        check("R1 cfg", cfg_q, 10'h000);

        // R8: writes below level 3 are ignored
        wr_cfg(2'b10, 10'h3FF); check("R8 lvl2", cfg_q, 10'h000);
        wr_cfg(2'b01, 10'h2AA); check("R8 lvl1", cfg_q, 10'h000);
        wr_cfg(2'b00, 10'h155); check("R8 lvl0", cfg_q, 10'h000);
        // src0 rise, src1 fall, src2 both, src3 level-low
        wr_cfg(2'b11, 10'h039); check("R8 lvl3", cfg_q, 10'h039);

        // R3 falling ignored in rise mode; R10 latency
        port_a[2] = 1'b0; step(3);
        check("R3 fall ignored", irq_req[0], 1'b0);
        port_a[2] = 1'b1;
        step(1); check("R10 edge1", irq_req[0], 1'b0);
        step(1); check("R10 edge2", irq_req[0], 1'b0);
        step(1); check("R10 edge3", irq_req[0], 1'b1);
        step(5); check("R3 held", irq_req, 4'h1);
        pulse_ack(4'h1); check("R11 ack clears", irq_req[0], 1'b0);

        // R4 / R2 source isolation on port F
        port_f[0] = 1'b0; step(3);
        check("R2 R4 only src1", irq_req, 4'h2);
        pulse_ack(4'h2);
        port_f[0] = 1'b1; step(3);
        check("R4 rise ignored", irq_req, 4'h0);

        // R5 both edges on source 2
        port_b[1] = 1'b0; step(3);
        check("R5 fall", irq_req, 4'h4);
        pulse_ack(4'h4);
        port_b[1] = 1'b1; step(3);
        check("R5 rise", irq_req, 4'h4);
        // R11 ack coincident with new edge keeps request
        port_b[1] = 1'b0; step(2);
        pulse_ack(4'h4);
        check("R11 coincident edge", irq_req[2], 1'b1);
        pulse_ack(4'h4);
        check("R11 plain ack", irq_req[2], 1'b0);

        // R9 flush on change, keep on same value
        port_b[1] = 1'b1; step(3);
        check("R9 pending", irq_req[2], 1'b1);
        wr_cfg(2'b11, 10'h039); check("R9 same value keeps", irq_req[2], 1'b1);
        wr_cfg(2'b11, 10'h019); check("R9 change clears", irq_req[2], 1'b0);

        // R6 level-low on source 3
        port_b[6] = 1'b0; step(3);
        check("R6 low level", irq_req[3], 1'b1);
        pulse_ack(4'h8); check("R6 ack no effect", irq_req[3], 1'b1);
        port_b[6] = 1'b1; step(3);
        check("R6 released", irq_req[3], 1'b0);

        // R7 high-level polarity on source 0
        wr_cfg(2'b11, 10'h118); step(1);
        check("R7 high active", irq_req[0], 1'b1);
        port_a = 4'h0; step(3);
        check("R7 all low", irq_req[0], 1'b0);
        port_a = 4'h2; step(3);
        check("R7 one high", irq_req[0], 1'b1);
        wr_cfg(2'b01, 10'h000);
        check("R8 locked cfg", cfg_q, 10'h118);
        check("R8 locked req", irq_req[0], 1'b1);

        // random phase, checked by the model every cycle
        for (int i = 0; i < 600; i++) begin
            if ($urandom_range(0, 3) == 0) port_a[$urandom_range(0, 3)] ^= 1'b1;
            if ($urandom_range(0, 3) == 0) port_f[$urandom_range(0, 2)] ^= 1'b1;
            if ($urandom_range(0, 2) == 0) port_b[$urandom_range(0, 7)] ^= 1'b1;
            irq_ack = 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15));
            if ($urandom_range(0, 15) == 0) begin
                cfg_we = 1'b1;
                irq_lvl = 2'($urandom_range(0, 3));
                cfg_wdata = 10'($urandom_range(0, 1023));
            end else begin
                cfg_we = 1'b0;
                irq_lvl = 2'($urandom_range(0, 3));
            end
            step(1);
        end
        cfg_we = 1'b0; irq_ack = '0;
        step(2);
        finish_run();
    end
endmodule